// File: doc/BRIEF.md
# Privileged register access gate

This block sits beside the system-instruction decoder and rules on every attempt to read or write one privileged partition-mapping register. It compares the instruction's five encoding fields with the register's own encoding and, on a hit, walks a fixed order of checks. These checks cover the implemented capabilities, the current privilege level, a three-bit nested-virtualization control and a top-level trap control. The result is a single action code.

Depending on the checks, the access is refused as UNDEFINED, sent as a trap to level 2 or level 3, redirected to a fixed offset in a memory-backed save area, or allowed to reach the register directly. A trap comes with the exception class that the trap logic places in the syndrome. The block is purely combinational. It does not take the trap, perform the memory access, or hold the register.

Top module: `sysreg_gate`

## Requirements
- R1: The encoding hits only when op0=2'b11, op1=3'b100, crn=4'b1010, crm=4'b0110 and op2=3'b001. On a miss, `action` is 0 (none), and `trap_ec`, `mem_ofs` and `mem_store` are 0. The action codes are: 0 none, 1 UNDEFINED, 2 trap to level 2, 3 trap to level 3, 4 redirect to memory, 5 direct access.
- R2: Reads and writes get the same action. `is_write` changes only `mem_store`.
- R3: On a hit, the action is 1 when any of these holds: `feat_present` is 0, `hcr_cap` is 0, or `map_top_idx` is 0. This check takes priority over all later ones.
- R4: A hit at `cur_el`=0 that passes R3 gives action 1.
- R5: At `cur_el`=1, when `nv_ctl[2]` and `nv_ctl[0]` are both 1, the action is 4, `mem_ofs` is 12'h948 and `mem_store` equals `is_write`.
- R6: At `cur_el`=1, when `nv_ctl[0]`=1 and `nv_ctl[2]`=0, the routing depends on `el3_present` and `trap_lower`. If both are 1, the action is 1 when `sdd_undef` is set and 3 when it is not. Otherwise the action is 2.
- R7: At `cur_el`=1 with `nv_ctl[0]`=0, the action is 1.
- R8: At `cur_el`=2, when `el3_present` and `trap_lower` are both 1, the action is 1 if `sdd_undef_pri` is set. If it is not set, the action is 1 when `sdd_undef` is set and 3 otherwise. Without both of those bits, the action is 5.
- R9: At `cur_el`=3, a hit that passes R3 gives action 5.
- R10: `trap_ec` is 6'h18 exactly when the action is 2 or 3, and 0 otherwise. `mem_ofs` and `mem_store` are 0 unless the action is 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op0 | input | 2 | Encoding field op0 |
| op1 | input | 3 | Encoding field op1 |
| crn | input | 4 | Encoding field CRn |
| crm | input | 4 | Encoding field CRm |
| op2 | input | 3 | Encoding field op2 |
| is_write | input | 1 | 1 for a write, 0 for a read |
| cur_el | input | 2 | Current privilege level |
| feat_present | input | 1 | Partitioning feature implemented |
| hcr_cap | input | 1 | Hypervisor-control capability present |
| map_top_idx | input | 3 | Highest implemented mapping register index |
| nv_ctl | input | 3 | Nested-virtualization control bits |
| el3_present | input | 1 | Level 3 implemented |
| trap_lower | input | 1 | Top-level trap-lower control |
| sdd_undef | input | 1 | Secure-debug: UNDEFINED instead of trap to level 3 |
| sdd_undef_pri | input | 1 | Secure-debug: UNDEFINED takes priority at level 2 |
| action | output | 3 | Action code (see R1) |
| trap_ec | output | 6 | Exception class for a trap |
| mem_ofs | output | 12 | Save-area offset on redirect |
| mem_store | output | 1 | Redirect is a store |

## Verification
The bench builds the block with its default parameters: the register's own encoding, a 3-bit mapping index, offset 12'h948 and class 6'h18. At these widths the full control space for a hitting encoding is small: 2^15 vectors of level, capability bits, index, nested-virtualization bits, trap controls, secure-debug flags and direction. The bench therefore sweeps that space exhaustively, so every branch of the priority order and every edge between two branches is reached, including index zero against nonzero. Seeded random encodings, plus every single-field miss, exercise the no-match path.

// File: rtl/sysreg_gate.sv
module sysreg_gate #(
  parameter logic [1:0] ENC_OP0 = 2'b11,
  parameter logic [2:0] ENC_OP1 = 3'b100,
  parameter logic [3:0] ENC_CRN = 4'b1010,
  parameter logic [3:0] ENC_CRM = 4'b0110,
  parameter logic [2:0] ENC_OP2 = 3'b001,
  parameter int IDX_W = 3,
  parameter int OFS_W = 12,
  parameter int EC_W  = 6,
  parameter logic [OFS_W-1:0] SAVE_OFS = 12'h948,
  parameter logic [EC_W-1:0]  TRAP_CLASS = 6'h18
) (
  input  logic [1:0]       op0,
  input  logic [2:0]       op1,
  input  logic [3:0]       crn,
  input  logic [3:0]       crm,
  input  logic [2:0]       op2,
  input  logic             is_write,
  input  logic [1:0]       cur_el,
  input  logic             feat_present,
  input  logic             hcr_cap,
  input  logic [IDX_W-1:0] map_top_idx,
  input  logic [2:0]       nv_ctl,
  input  logic             el3_present,
  input  logic             trap_lower,
  input  logic             sdd_undef,
  input  logic             sdd_undef_pri,
  output logic [2:0]       action,
  output logic [EC_W-1:0]  trap_ec,
  output logic [OFS_W-1:0] mem_ofs,
  output logic             mem_store
);
  localparam logic [2:0] A_NONE  = 3'd0;
  localparam logic [2:0] A_UNDEF = 3'd1;
  localparam logic [2:0] A_TRAP2 = 3'd2;
  localparam logic [2:0] A_TRAP3 = 3'd3;
  localparam logic [2:0] A_REDIR = 3'd4;
  localparam logic [2:0] A_DIRECT = 3'd5;

  wire hit      = (op0 == ENC_OP0) && (op1 == ENC_OP1) && (crn == ENC_CRN)
               && (crm == ENC_CRM) && (op2 == ENC_OP2);
  wire capable  = feat_present && hcr_cap && (map_top_idx != '0);
  wire top_trap = el3_present && trap_lower;
  wire nv_redir = nv_ctl[2] && nv_ctl[0];
  wire [2:0] top_route = sdd_undef ? A_UNDEF : A_TRAP3;

  always_comb begin
    if (!hit)          action = A_NONE;
    else if (!capable) action = A_UNDEF;
    else begin
      unique case (cur_el)
        2'd0: action = A_UNDEF;
        2'd1: begin
          if (nv_redir)       action = A_REDIR;
          else if (nv_ctl[0]) action = top_trap ? top_route : A_TRAP2;
          else                action = A_UNDEF;
        end
        2'd2: begin
          if (top_trap && sdd_undef_pri) action = A_UNDEF;
          else if (top_trap)             action = top_route;
          else                           action = A_DIRECT;
        end
        default: action = A_DIRECT;
      endcase
    end
  end

  assign trap_ec   = (action == A_TRAP2 || action == A_TRAP3) ? TRAP_CLASS : '0;
  assign mem_ofs   = (action == A_REDIR) ? SAVE_OFS : '0;
  assign mem_store = (action == A_REDIR) && is_write;
endmodule

// File: rtl/sysreg_gate_chk.sv
module sysreg_gate_chk (
  input logic [1:0] op0,
  input logic [2:0] op1,
  input logic [3:0] crn,
  input logic [3:0] crm,
  input logic [2:0] op2,
  input logic       is_write,
  input logic [1:0] cur_el,
  input logic       feat_present,
  input logic       hcr_cap,
  input logic [2:0] map_top_idx,
  input logic [2:0] nv_ctl,
  input logic       el3_present,
  input logic       trap_lower,
  input logic       sdd_undef,
  input logic       sdd_undef_pri,
  input logic [2:0] action,
  input logic [5:0] trap_ec,
  input logic [11:0] mem_ofs,
  input logic       mem_store
);
  wire known = !$isunknown({op0, op1, crn, crm, op2, is_write, cur_el, feat_present,
                            hcr_cap, map_top_idx, nv_ctl, el3_present, trap_lower,
                            sdd_undef, sdd_undef_pri});
  wire match = {op0, op1, crn, crm, op2} == {2'b11, 3'b100, 4'b1010, 4'b0110, 3'b001};
  wire gated = match && feat_present && hcr_cap && map_top_idx != 3'd0;

  always_comb begin
    if (known) begin
      p_miss_quiet_r1: assert (match || {action, trap_ec, mem_ofs, mem_store} == '0);
      p_cap_undef_r3: assert (!(match && !gated) || action == 3'd1);
      p_el0_undef_r4: assert (!(gated && cur_el == 2'd0) || action == 3'd1);
      p_redirect_r5: assert (!(gated && cur_el == 2'd1 && nv_ctl[2] && nv_ctl[0])
                             || (action == 3'd4 && mem_ofs == 12'h948 && mem_store == is_write));
      p_el1_clear_r7: assert (!(gated && cur_el == 2'd1 && !nv_ctl[0]) || action == 3'd1);
      p_el3_direct_r9: assert (!(gated && cur_el == 2'd3) || action == 3'd5);
      p_class_r10: assert ((trap_ec == 6'h18) == (action == 3'd2 || action == 3'd3)
                           && (trap_ec == 6'h18 || trap_ec == 6'h0));
      p_ofs_only_redirect_r10: assert (action == 3'd4 || (mem_ofs == '0 && !mem_store));
    end
  end
endmodule

bind sysreg_gate sysreg_gate_chk u_chk (.*);

// File: tb/sysreg_gate_test.sv
module sysreg_gate_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [1:0] op0; logic [2:0] op1; logic [3:0] crn, crm; logic [2:0] op2;
  logic is_write, feat_present, hcr_cap, el3_present, trap_lower, sdd_undef, sdd_undef_pri;
  logic [1:0] cur_el; logic [2:0] map_top_idx, nv_ctl;
  logic [2:0] action; logic [5:0] trap_ec; logic [11:0] mem_ofs; logic mem_store;

  int checks = 0, fails = 0;
  bit done = 0;

  sysreg_gate uut (.*);

  function automatic logic [2:0] exp_act(logic hit);
    if (!hit) return 3'd0;
    if (!feat_present || !hcr_cap || map_top_idx == 0) return 3'd1;
    case (cur_el)
      2'd0: return 3'd1;
      2'd1: if (nv_ctl[2] && nv_ctl[0]) return 3'd4;
            else if (nv_ctl[0]) return (el3_present && trap_lower) ? (sdd_undef ? 3'd1 : 3'd3) : 3'd2;
            else return 3'd1;
      2'd2: if (el3_present && trap_lower) return (sdd_undef_pri || sdd_undef) ? 3'd1 : 3'd3;
            else return 3'd5;
      default: return 3'd5;
    endcase
  endfunction

  function automatic string req_of(logic hit);
    if (!hit) return "R1";
    if (!feat_present || !hcr_cap || map_top_idx == 0) return "R3";
    case (cur_el)
      2'd0: return "R4";
      2'd1: return nv_ctl[0] ? (nv_ctl[2] ? "R5" : "R6") : "R7";
      2'd2: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply_and_check(logic hit);
    logic [2:0] ea; logic [5:0] ee; logic [11:0] eo; logic es;
    @(posedge clk); #1;
    ea = exp_act(hit);
    ee = (ea == 3'd2 || ea == 3'd3) ? 6'h18 : 6'h0;
    eo = (ea == 3'd4) ? 12'h948 : 12'h0;
    es = (ea == 3'd4) && is_write;
    chk({req_of(hit), " and R2"}, {29'd0, action}, {29'd0, ea});
    chk("R10", {14'd0, trap_ec, mem_ofs}, {14'd0, ee, eo});
    if (ea == 3'd4) chk("R5", {31'd0, mem_store}, {31'd0, es});
    else chk("R10", {31'd0, mem_store}, 32'd0);
  endtask

  task automatic set_match();
    op0 = 2'b11; op1 = 3'b100; crn = 4'b1010; crm = 4'b0110; op2 = 3'b001;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    set_match(); is_write = 0; cur_el = 0; feat_present = 0; hcr_cap = 0;
    map_top_idx = 0; nv_ctl = 0; el3_present = 0; trap_lower = 0; sdd_undef = 0; sdd_undef_pri = 0;
    apply_and_check(1'b1);
    for (int v = 0; v < 32768; v++) begin
      {cur_el, feat_present, hcr_cap, map_top_idx, nv_ctl, el3_present,
       trap_lower, sdd_undef, sdd_undef_pri, is_write} = v[14:0];
      apply_and_check(1'b1);
    end
    // R1: each field off by one bit with everything else permissive
    for (int f = 0; f < 5; f++) begin
      set_match(); cur_el = 3; feat_present = 1; hcr_cap = 1; map_top_idx = 1;
      nv_ctl = 3'b101; is_write = 1;
      case (f)
        0: op0 ^= 2'b01; 1: op1 ^= 3'b001; 2: crn ^= 4'b0001;
        3: crm ^= 4'b1000; default: op2 ^= 3'b100;
      endcase
      apply_and_check(1'b0);
    end
    for (int i = 0; i < 4000; i++) begin
      {op0, op1, crn, crm, op2} = 16'($urandom);
      {cur_el, feat_present, hcr_cap, map_top_idx, nv_ctl, el3_present,
       trap_lower, sdd_undef, sdd_undef_pri, is_write} = 15'($urandom);
      if ($urandom % 4 == 0) set_match();
      apply_and_check({op0, op1, crn, crm, op2} == {2'b11, 3'b100, 4'b1010, 4'b0110, 3'b001});
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (190000) @(posedge clk); checks++; fails++; $display("FAIL watchdog: got hang expected completion"); end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule